// File: doc/BRIEF.md
# Front-End Early Execution Stage

This block sits beside register rename and evaluates, in program order, a group of up to `LANES` micro-ops per accepted transfer. Each lane owns one fixed single-cycle integer ALU. A micro-op is early-executed only when it is a simple ALU operation and each of its two operands can be produced without touching the register file. An operand can come from the micro-op's own immediate, from a value-predicted operand that the front end supplies, from the result prediction of an older micro-op in the same group, or from a result that the previous accepted group computed here. Any micro-op that misses an operand is not held back. It is marked as not executed and continues to the out-of-order engine. The rest of its group is evaluated normally.

For each lane the stage reports three things. The first is whether the micro-op was executed and, if so, its result. The second is the result prediction that goes forward to be written into the register file at dispatch. The third is whether that prediction fed an early-executed consumer in the same group, in which case it still has to be validated at commit. The stage has one register level with a valid/ready handshake on each side. A squash clears the one-group bypass state and discards the pending output group.

Top module: `ee_stage`

## Requirements
- R1: Opcodes 0 to 8 (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 shift left, 6 logical shift right, 7 arithmetic shift right, 8 move) are eligible. Any opcode of 9 or above (9 load, 10 store, 11 multiply, 12 divide, others) is never reported as executed, whatever its operands are.
- R2: An executed micro-op's result is a+b, a-b, a&b, a|b or a^b. For shifts, a is shifted by the low log2(XLEN) bits of b. A move returns a.
- R3: Source kind 0 means the operand is unused and reads as zero. Kind 1 selects the lane's immediate. Kind 2 names an architectural register. A register operand is available only through R4, R5, or an operand prediction (a set bit in `in_opnd_pv`, at bit 2·lane for A and 2·lane+1 for B). A micro-op with a missing operand gets done=0 and result 0, and the other lanes are not affected.
- R4: A register operand that has no writer earlier in its own group takes the value from the latest writer of that register in the immediately previous accepted group, but only if that writer was early-executed. If that latest writer was not executed, the operand prediction is used when present. Results from two or more groups back are never forwarded.
- R5: When an earlier lane in the same group writes the register, that latest earlier writer decides the operand. Its result prediction is used if it has one. Otherwise the operand is unavailable, even when an operand prediction or a bypass value exists.
- R6: `out_need_check` for a lane is 1 exactly when that lane carried a result prediction and a later, early-executed lane of the same group took it as an operand.
- R7: `out_pred_vld`/`out_pred_val` repeat each valid lane's result prediction, with a value of 0 when there is none.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the output group stays unchanged.
- R9: A cycle with `flush` high accepts nothing, drops `out_valid` at the next edge, and empties the bypass state, so the next group sees no previous-group results.
- R10: A lane with `in_slot_vld` low reports all zeros and forwards nothing to the next group.
- R11: After reset `out_valid` is 0, `in_ready` is 1 and the bypass is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Pipeline squash |
| in_valid | input | 1 | Input group valid |
| in_ready | output | 1 | Stage can take a group |
| in_slot_vld | input | LANES | Lane holds a micro-op |
| in_op | input | LANES*4 | Opcode per lane |
| in_dst_vld | input | LANES | Lane writes a register |
| in_dst | input | LANES*RW | Destination register per lane |
| in_srca_kind | input | LANES*2 | Operand A source kind |
| in_srca_reg | input | LANES*RW | Operand A register |
| in_srcb_kind | input | LANES*2 | Operand B source kind |
| in_srcb_reg | input | LANES*RW | Operand B register |
| in_imm | input | LANES*XLEN | Immediate per lane |
| in_opnd_pv | input | LANES*2 | Operand prediction valid (A, B per lane) |
| in_opnd_pval | input | LANES*2*XLEN | Operand prediction values |
| in_res_pv | input | LANES | Result prediction valid |
| in_res_pval | input | LANES*XLEN | Result prediction values |
| out_valid | output | 1 | Output group valid |
| out_ready | input | 1 | Downstream accepts the group |
| out_slot_vld | output | LANES | Lane valid |
| out_ee_done | output | LANES | Lane was early-executed |
| out_ee_result | output | LANES*XLEN | Early result per lane |
| out_pred_vld | output | LANES | Prediction to write at dispatch |
| out_pred_val | output | LANES*XLEN | Prediction value per lane |
| out_need_check | output | LANES | Prediction consumed in group, validate |

## Verification
The hardest situation to reach from the ports is the one where several sources compete for one register operand. An earlier writer in the same group, a writer in the previous group that was not executed, a stale earlier writer in that previous group that was executed, and an operand prediction can all be present at once. The stimulus builds this with back-to-back groups. One group makes an executed lane and a later non-executed lane write the same register, and the next group reads that register with and without an operand prediction. A third group reads registers written two groups back. Intra-group cases place a predicted producer and a non-predicted producer ahead of consumers that also carry operand predictions. Flush and backpressure are each applied while an output group is being held.

// File: rtl/ee_pkg.sv
package ee_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_IMM  = 2'd1,
    SRC_REG  = 2'd2
  } src_kind_e;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_SLL   = 4'd5,
    OP_SRL   = 4'd6,
    OP_SRA   = 4'd7,
    OP_MOV   = 4'd8,
    OP_LOAD  = 4'd9,
    OP_STORE = 4'd10,
    OP_MUL   = 4'd11,
    OP_DIV   = 4'd12
  } op_e;

  localparam int OP_W   = 4;
  localparam int KIND_W = 2;

  // single-cycle integer class: everything up to and including move
  function automatic logic op_is_alu(input logic [OP_W-1:0] op);
    return op <= 4'(OP_MOV);
  endfunction

endpackage

// File: rtl/ee_alu.sv
module ee_alu
  import ee_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res
);
  localparam int SH_W = $clog2(XLEN);

  function automatic logic [XLEN-1:0] alu_eval(input logic [OP_W-1:0] f,
                                               input logic [XLEN-1:0] x,
                                               input logic [XLEN-1:0] y);
    logic [SH_W-1:0] amt;
    amt = y[SH_W-1:0];
    case (op_e'(f))
      OP_ADD:  return x + y;
      OP_SUB:  return x - y;
      OP_AND:  return x & y;
      OP_OR:   return x | y;
      OP_XOR:  return x ^ y;
      OP_SLL:  return x << amt;
      OP_SRL:  return x >> amt;
      OP_SRA:  return XLEN'($signed(x) >>> amt);
      OP_MOV:  return x;
      default: return '0;
    endcase
  endfunction

  assign res = alu_eval(op, a, b);
endmodule

// File: rtl/ee_operand_sel.sv
module ee_operand_sel
  import ee_pkg::*;
#(
  parameter int LANES = 4,
  parameter int XLEN  = 64,
  parameter int RW    = 5,
  parameter int SLOT  = 0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [KIND_W-1:0]               kind,
  input  logic [RW-1:0]                   src_reg,
  input  logic [XLEN-1:0]                 imm,
  input  logic                            opnd_pv,
  input  logic [XLEN-1:0]                 opnd_pval,
  input  logic [LANES-1:0]                grp_wr,
  input  logic [LANES-1:0][RW-1:0]        grp_dst,
  input  logic [LANES-1:0]                grp_rpv,
  input  logic [LANES-1:0][XLEN-1:0]      grp_rpval,
  input  logic [LANES-1:0]                byp_wr,
  input  logic [LANES-1:0]                byp_exec,
  input  logic [LANES-1:0][RW-1:0]        byp_dst,
  input  logic [LANES-1:0][XLEN-1:0]      byp_val,
  output logic                            avail,
  output logic [XLEN-1:0]                 value,
  output logic [LANES-1:0]                use_oh
);
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;

  logic          intra_hit;
  logic [IW-1:0] intra_idx;
  logic          byp_hit;
  logic [IW-1:0] byp_idx;

  // latest older writer inside the group (ascending scan, last match wins)
  always_comb begin
    intra_hit = 1'b0;
    intra_idx = '0;
    for (int j = 0; j < LANES; j++) begin
      if ((j < SLOT) && grp_wr[j] && (grp_dst[j] == src_reg)) begin
        intra_hit = 1'b1;
        intra_idx = IW'(j);
      end
    end
  end

  // latest writer of the previous accepted group
  always_comb begin
    byp_hit = 1'b0;
    byp_idx = '0;
    for (int j = 0; j < LANES; j++) begin
      if (byp_wr[j] && (byp_dst[j] == src_reg)) begin
        byp_hit = 1'b1;
        byp_idx = IW'(j);
      end
    end
  end

  always_comb begin
    avail  = 1'b0;
    value  = '0;
    use_oh = '0;
    case (src_kind_e'(kind))
      SRC_NONE: avail = 1'b1;
      SRC_IMM: begin
        avail = 1'b1;
        value = imm;
      end
      SRC_REG: begin
        if (intra_hit) begin
          avail = grp_rpv[intra_idx];
          value = grp_rpv[intra_idx] ? grp_rpval[intra_idx] : '0;
          use_oh[intra_idx] = grp_rpv[intra_idx];
        end else if (byp_hit && byp_exec[byp_idx]) begin
          avail = 1'b1;
          value = byp_val[byp_idx];
        end else if (opnd_pv) begin
          avail = 1'b1;
          value = opnd_pval;
        end
      end
      default: avail = 1'b0;
    endcase
  end

  // R3/R5: a predicted register operand with no older in-group writer is never lost
  a_r3_pred_operand_used: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == 2'(SRC_REG)) && opnd_pv && !intra_hit) |-> avail);

  // R5: an in-group producer is consumed only through its prediction
  a_r5_intra_only_pred: assert property (@(posedge clk) disable iff (!rst_n)
    (use_oh != '0) |-> ((use_oh & ~grp_rpv) == '0));
endmodule

// File: rtl/ee_bypass.sv
module ee_bypass #(
  parameter int LANES = 4,
  parameter int XLEN  = 64,
  parameter int RW    = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       load,
  input  logic [LANES-1:0]           nxt_wr,
  input  logic [LANES-1:0]           nxt_exec,
  input  logic [LANES-1:0][RW-1:0]   nxt_dst,
  input  logic [LANES-1:0][XLEN-1:0] nxt_val,
  output logic [LANES-1:0]           byp_wr,
  output logic [LANES-1:0]           byp_exec,
  output logic [LANES-1:0][RW-1:0]   byp_dst,
  output logic [LANES-1:0][XLEN-1:0] byp_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_wr   <= '0;
      byp_exec <= '0;
      byp_dst  <= '0;
      byp_val  <= '0;
    end else if (clear) begin
      byp_wr   <= '0;
      byp_exec <= '0;
    end else if (load) begin
      byp_wr   <= nxt_wr;
      byp_exec <= nxt_exec & nxt_wr;
      byp_dst  <= nxt_dst;
      byp_val  <= nxt_val;
    end
  end

  // R9: a squash leaves no forwardable result behind
  a_r9_flush_empties_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (byp_wr == '0) && (byp_exec == '0));
endmodule

// File: rtl/ee_stage.sv
module ee_stage
  import ee_pkg::*;
#(
  parameter int LANES = 4,
  parameter int XLEN  = 64,
  parameter int RW    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES-1:0]          in_slot_vld,
  input  logic [LANES*OP_W-1:0]     in_op,
  input  logic [LANES-1:0]          in_dst_vld,
  input  logic [LANES*RW-1:0]       in_dst,
  input  logic [LANES*KIND_W-1:0]   in_srca_kind,
  input  logic [LANES*RW-1:0]       in_srca_reg,
  input  logic [LANES*KIND_W-1:0]   in_srcb_kind,
  input  logic [LANES*RW-1:0]       in_srcb_reg,
  input  logic [LANES*XLEN-1:0]     in_imm,
  input  logic [LANES*2-1:0]        in_opnd_pv,
  input  logic [LANES*2*XLEN-1:0]   in_opnd_pval,
  input  logic [LANES-1:0]          in_res_pv,
  input  logic [LANES*XLEN-1:0]     in_res_pval,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANES-1:0]          out_slot_vld,
  output logic [LANES-1:0]          out_ee_done,
  output logic [LANES*XLEN-1:0]     out_ee_result,
  output logic [LANES-1:0]          out_pred_vld,
  output logic [LANES*XLEN-1:0]     out_pred_val,
  output logic [LANES-1:0]          out_need_check
);
  logic [LANES-1:0][OP_W-1:0] op_u;
  logic [LANES-1:0][RW-1:0]   dst_u;
  logic [LANES-1:0][XLEN-1:0] rpval_u;
  logic [LANES-1:0]           grp_wr;
  logic [LANES-1:0]           grp_rpv;

  logic [LANES-1:0]           byp_wr;
  logic [LANES-1:0]           byp_exec;
  logic [LANES-1:0][RW-1:0]   byp_dst;
  logic [LANES-1:0][XLEN-1:0] byp_val;

  logic [LANES-1:0]             av_a, av_b;
  logic [LANES-1:0][XLEN-1:0]   opa, opb, alu_res;
  logic [LANES-1:0][LANES-1:0]  use_a, use_b;
  logic [LANES-1:0]             exec_c;
  logic [LANES-1:0]             consumed_c;
  logic [LANES-1:0]             need_c;

  logic accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready && !flush;
  assign grp_wr   = in_slot_vld & in_dst_vld;
  assign grp_rpv  = in_slot_vld & in_res_pv;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign op_u[g]    = in_op[g*OP_W +: OP_W];
    assign dst_u[g]   = in_dst[g*RW +: RW];
    assign rpval_u[g] = in_res_pval[g*XLEN +: XLEN];

    ee_operand_sel #(.LANES(LANES), .XLEN(XLEN), .RW(RW), .SLOT(g)) u_sel_a (
      .clk(clk), .rst_n(rst_n),
      .kind(in_srca_kind[g*KIND_W +: KIND_W]), .src_reg(in_srca_reg[g*RW +: RW]),
      .imm(in_imm[g*XLEN +: XLEN]),
      .opnd_pv(in_opnd_pv[2*g]), .opnd_pval(in_opnd_pval[(2*g)*XLEN +: XLEN]),
      .grp_wr(grp_wr), .grp_dst(dst_u), .grp_rpv(grp_rpv), .grp_rpval(rpval_u),
      .byp_wr(byp_wr), .byp_exec(byp_exec), .byp_dst(byp_dst), .byp_val(byp_val),
      .avail(av_a[g]), .value(opa[g]), .use_oh(use_a[g])
    );

    ee_operand_sel #(.LANES(LANES), .XLEN(XLEN), .RW(RW), .SLOT(g)) u_sel_b (
      .clk(clk), .rst_n(rst_n),
      .kind(in_srcb_kind[g*KIND_W +: KIND_W]), .src_reg(in_srcb_reg[g*RW +: RW]),
      .imm(in_imm[g*XLEN +: XLEN]),
      .opnd_pv(in_opnd_pv[2*g+1]), .opnd_pval(in_opnd_pval[(2*g+1)*XLEN +: XLEN]),
      .grp_wr(grp_wr), .grp_dst(dst_u), .grp_rpv(grp_rpv), .grp_rpval(rpval_u),
      .byp_wr(byp_wr), .byp_exec(byp_exec), .byp_dst(byp_dst), .byp_val(byp_val),
      .avail(av_b[g]), .value(opb[g]), .use_oh(use_b[g])
    );

    ee_alu #(.XLEN(XLEN)) u_alu (
      .op(op_u[g]), .a(opa[g]), .b(opb[g]), .res(alu_res[g])
    );

    assign exec_c[g] = in_slot_vld[g] && op_is_alu(op_u[g]) && av_a[g] && av_b[g];
  end

  // which producer predictions were taken by an executing later lane
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      consumed_c[j] = 1'b0;
      for (int k = 0; k < LANES; k++) begin
        consumed_c[j] = consumed_c[j] | (exec_c[k] & (use_a[k][j] | use_b[k][j]));
      end
    end
  end
  assign need_c = grp_rpv & consumed_c;

  ee_bypass #(.LANES(LANES), .XLEN(XLEN), .RW(RW)) u_bypass (
    .clk(clk), .rst_n(rst_n), .clear(flush), .load(accept),
    .nxt_wr(grp_wr), .nxt_exec(exec_c), .nxt_dst(dst_u), .nxt_val(alu_res),
    .byp_wr(byp_wr), .byp_exec(byp_exec), .byp_dst(byp_dst), .byp_val(byp_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_slot_vld   <= '0;
      out_ee_done    <= '0;
      out_ee_result  <= '0;
      out_pred_vld   <= '0;
      out_pred_val   <= '0;
      out_need_check <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid      <= 1'b1;
      out_slot_vld   <= in_slot_vld;
      out_ee_done    <= exec_c;
      out_pred_vld   <= grp_rpv;
      out_need_check <= need_c;
      for (int g = 0; g < LANES; g++) begin
        out_ee_result[g*XLEN +: XLEN] <= exec_c[g] ? alu_res[g] : '0;
        out_pred_val[g*XLEN +: XLEN]  <= grp_rpv[g] ? rpval_u[g] : '0;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: backpressure holds the group
  a_r8_hold_group: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_ee_result)
                                             && $stable(out_ee_done)));
  // R8: no acceptance while the held group waits
  a_r8_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  // R9: squash empties the output
  a_r9_flush_drops_output: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
  // R10: empty lanes stay silent
  a_r10_idle_lane_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_ee_done | out_pred_vld | out_need_check) & ~out_slot_vld) == '0));
  // R6: validation flag only on a forwarded prediction
  a_r6_check_has_pred: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_need_check & ~out_pred_vld) == '0));
endmodule

// File: tb/ee_stage_tb.sv
module ee_stage_tb_top;
  localparam int L = 4;
  localparam int X = 64;
  localparam int R = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [L-1:0]     in_slot_vld;
  logic [L*4-1:0]   in_op;
  logic [L-1:0]     in_dst_vld;
  logic [L*R-1:0]   in_dst;
  logic [L*2-1:0]   in_srca_kind;
  logic [L*R-1:0]   in_srca_reg;
  logic [L*2-1:0]   in_srcb_kind;
  logic [L*R-1:0]   in_srcb_reg;
  logic [L*X-1:0]   in_imm;
  logic [L*2-1:0]   in_opnd_pv;
  logic [L*2*X-1:0] in_opnd_pval;
  logic [L-1:0]     in_res_pv;
  logic [L*X-1:0]   in_res_pval;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [L-1:0]     out_slot_vld, out_ee_done, out_pred_vld, out_need_check;
  logic [L*X-1:0]   out_ee_result, out_pred_val;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ee_stage #(.LANES(L), .XLEN(X), .RW(R)) dut_i (.*);

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] res(int s);
    return out_ee_result[s*X +: X];
  endfunction

  task automatic clr();
    in_slot_vld = '0; in_op = '0; in_dst_vld = '0; in_dst = '0;
    in_srca_kind = '0; in_srca_reg = '0; in_srcb_kind = '0; in_srcb_reg = '0;
    in_imm = '0; in_opnd_pv = '0; in_opnd_pval = '0; in_res_pv = '0; in_res_pval = '0;
  endtask

  // kinds: 0 unused, 1 immediate, 2 register
  task automatic uop(int s, logic [3:0] op, logic dv, logic [4:0] dst,
                     logic [1:0] ak, logic [4:0] ar, logic [1:0] bk, logic [4:0] br,
                     logic [63:0] imm);
    in_slot_vld[s] = 1'b1;
    in_op[s*4 +: 4] = op;
    in_dst_vld[s] = dv;
    in_dst[s*R +: R] = dst;
    in_srca_kind[s*2 +: 2] = ak; in_srca_reg[s*R +: R] = ar;
    in_srcb_kind[s*2 +: 2] = bk; in_srcb_reg[s*R +: R] = br;
    in_imm[s*X +: X] = imm;
  endtask

  task automatic opred(int s, int which, logic [63:0] v);
    in_opnd_pv[2*s+which] = 1'b1;
    in_opnd_pval[(2*s+which)*X +: X] = v;
  endtask

  task automatic rpred(int s, logic [63:0] v);
    in_res_pv[s] = 1'b1;
    in_res_pval[s*X +: X] = v;
  endtask

  task automatic send();
    @(negedge clk);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11", "out_valid in reset", 64'(out_valid), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "out_valid after reset", 64'(out_valid), 64'd0);
    chk("R11", "in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_ops_logic();
    logic [63:0] pa = 64'hF0F0_0000_0000_1234;
    logic [63:0] im = 64'h0000_0000_0000_0F0F;
    clr();
    for (int s = 0; s < 4; s++) begin
      uop(s, 4'(s), 1'b1, 5'(20 + s), 2'd2, 5'd30, 2'd1, 5'd0, im);
      opred(s, 0, pa);
    end
    send();
    chk("R2", "add", res(0), pa + im);
    chk("R2", "sub", res(1), pa - im);
    chk("R2", "and", res(2), pa & im);
    chk("R2", "or",  res(3), pa | im);
    chk("R1", "done all", 64'(out_ee_done), 64'hF);
    chk("R8", "out_valid", 64'(out_valid), 64'd1);
  endtask

  task automatic t_ops_shift();
    logic [63:0] pa = 64'h8000_0000_0000_00F0;
    logic [63:0] im = 64'h44; // amount 68 masks to 4
    clr();
    for (int s = 0; s < 4; s++) begin
      uop(s, 4'(4 + s), 1'b1, 5'(24 + s), 2'd2, 5'd30, 2'd1, 5'd0, im);
      opred(s, 0, pa);
    end
    send();
    chk("R2", "xor", res(0), pa ^ im);
    chk("R2", "sll", res(1), 64'h0000_0000_0000_0F00);
    chk("R2", "srl", res(2), 64'h0800_0000_0000_000F);
    chk("R2", "sra", res(3), 64'hF800_0000_0000_000F);
  endtask

  task automatic t_ops_misc();
    clr();
    uop(0, 4'd8, 1'b1, 5'd1, 2'd2, 5'd30, 2'd0, 5'd0, 64'd0);
    opred(0, 0, 64'hABCD);
    uop(1, 4'd9, 1'b1, 5'd2, 2'd1, 5'd0, 2'd1, 5'd0, 64'd3);
    rpred(1, 64'h55);
    uop(2, 4'd11, 1'b1, 5'd3, 2'd1, 5'd0, 2'd1, 5'd0, 64'd3);
    uop(3, 4'd0, 1'b1, 5'd4, 2'd0, 5'd0, 2'd1, 5'd0, 64'd7);
    send();
    chk("R2", "move", res(0), 64'hABCD);
    chk("R1", "load/mul not done", 64'(out_ee_done), 64'b1001);
    chk("R3", "unused operand zero", res(3), 64'd7);
    chk("R3", "skipped lane result zero", res(1), 64'd0);
    chk("R7", "pred vld", 64'(out_pred_vld), 64'b0010);
    chk("R7", "pred val", out_pred_val[1*X +: X], 64'h55);
  endtask

  task automatic t_bypass();
    clr();
    uop(0, 4'd0, 1'b1, 5'd3, 2'd1, 5'd0, 2'd1, 5'd0, 64'd10);
    uop(1, 4'd0, 1'b1, 5'd3, 2'd2, 5'd9, 2'd1, 5'd0, 64'd1);
    uop(2, 4'd0, 1'b1, 5'd6, 2'd1, 5'd0, 2'd1, 5'd0, 64'd1);
    uop(3, 4'd0, 1'b1, 5'd7, 2'd1, 5'd0, 2'd1, 5'd0, 64'd9);
    rpred(3, 64'h77);
    in_slot_vld[3] = 1'b0;
    send();
    chk("R3", "missing reg operand", 64'(out_ee_done), 64'b0101);
    chk("R10", "idle lane silent", 64'({out_pred_vld[3], out_ee_done[3]}), 64'd0);
    clr();
    uop(0, 4'd0, 1'b1, 5'd1, 2'd2, 5'd3, 2'd1, 5'd0, 64'd1);
    uop(1, 4'd0, 1'b1, 5'd8, 2'd2, 5'd6, 2'd1, 5'd0, 64'd5);
    uop(2, 4'd8, 1'b1, 5'd7, 2'd2, 5'd6, 2'd0, 5'd0, 64'd0);
    uop(3, 4'd0, 1'b1, 5'd2, 2'd2, 5'd3, 2'd1, 5'd0, 64'd0);
    opred(3, 0, 64'd100);
    send();
    chk("R4", "latest prev writer unexecuted", 64'(out_ee_done[0]), 64'd0);
    chk("R4", "bypass add", res(1), 64'd7);
    chk("R4", "bypass move", res(2), 64'd2);
    chk("R4", "fallback to operand pred", res(3), 64'd100);
    clr();
    uop(0, 4'd0, 1'b1, 5'd10, 2'd2, 5'd6, 2'd1, 5'd0, 64'd1);
    uop(1, 4'd0, 1'b1, 5'd11, 2'd2, 5'd7, 2'd1, 5'd0, 64'd1);
    send();
    chk("R4", "two groups back / one back", 64'(out_ee_done[1:0]), 64'b10);
    chk("R4", "one back value", res(1), 64'd3);
  endtask

  task automatic t_intra();
    clr();
    uop(0, 4'd0, 1'b1, 5'd4, 2'd1, 5'd0, 2'd1, 5'd0, 64'd3);
    rpred(0, 64'h40);
    uop(1, 4'd0, 1'b1, 5'd5, 2'd2, 5'd9, 2'd1, 5'd0, 64'd1);
    uop(2, 4'd0, 1'b1, 5'd12, 2'd2, 5'd4, 2'd1, 5'd0, 64'd1);
    uop(3, 4'd0, 1'b1, 5'd13, 2'd2, 5'd5, 2'd1, 5'd0, 64'd1);
    opred(3, 0, 64'h99);
    send();
    chk("R5", "done map", 64'(out_ee_done), 64'b0101);
    chk("R5", "uses producer prediction", res(2), 64'h41);
    chk("R5", "producer own result", res(0), 64'd6);
    chk("R6", "need_check", 64'(out_need_check), 64'b0001);
    clr();
    uop(0, 4'd9, 1'b1, 5'd4, 2'd1, 5'd0, 2'd1, 5'd0, 64'd0);
    rpred(0, 64'h10);
    uop(1, 4'd0, 1'b1, 5'd14, 2'd2, 5'd4, 2'd2, 5'd20, 64'd0);
    send();
    chk("R6", "consumer not executed", 64'(out_need_check), 64'd0);
    chk("R6", "consumer done", 64'(out_ee_done), 64'd0);
  endtask

  task automatic t_flush();
    clr();
    uop(0, 4'd0, 1'b1, 5'd15, 2'd1, 5'd0, 2'd1, 5'd0, 64'd2);
    @(negedge clk); out_ready = 1'b0;
    send();
    chk("R9", "held before flush", 64'(out_valid), 64'd1);
    flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    chk("R9", "flush drops output", 64'(out_valid), 64'd0);
    out_ready = 1'b1;
    clr();
    uop(0, 4'd0, 1'b1, 5'd16, 2'd2, 5'd15, 2'd1, 5'd0, 64'd0);
    send();
    chk("R9", "bypass emptied", 64'(out_ee_done[0]), 64'd0);
  endtask

  task automatic t_backpressure();
    clr();
    uop(0, 4'd0, 1'b1, 5'd17, 2'd1, 5'd0, 2'd1, 5'd0, 64'd21);
    @(negedge clk); out_ready = 1'b0;
    send();
    chk("R8", "first group", res(0), 64'd42);
    clr();
    uop(0, 4'd0, 1'b1, 5'd18, 2'd1, 5'd0, 2'd1, 5'd0, 64'd5);
    in_valid = 1'b1;
    #0;
    chk("R8", "in_ready low when held", 64'(in_ready), 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R8", "held result", res(0), 64'd42);
    chk("R8", "held valid", 64'(out_valid), 64'd1);
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk("R8", "second group after release", res(0), 64'd10);
  endtask

  initial begin
    clr();
    @(negedge clk);
    t_reset();
    t_ops_logic();
    t_ops_shift();
    t_ops_misc();
    t_bypass();
    t_intra();
    t_flush();
    t_backpressure();
    report();
  end
endmodule